// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the pin-level timing that an 8-bit controller core needs to reach code and data memory outside the chip. Time is divided into slots of six oscillator periods. In each slot the block either leaves the bus idle, runs one external code fetch, or runs one half of a twelve-period external data access. Its outputs are the address latch strobe, an active-low program-store strobe, active-low read and write strobes, a multiplexed port that carries the low address byte and then the data byte, a high-address byte and a page byte for wide data addresses.

Two strap inputs are sampled once, on the first clock after reset is released. The external-access strap decides whether the lower code window, up to address F7FFh, is served internally. Code above that window always goes out to the bus. The level on the program-store pin at the same moment sets a serial-download flag. A control input keeps the address latch strobe low at all times. When the multiplexed port is not acting as a bus, it behaves as an open-drain port driven from a latch value.

Requests for data accesses are one-cycle pulses. The block captures each pulse and starts the access at the next slot boundary. A data access takes priority over a code fetch. The code-fetch request is a level that is sampled at every slot boundary.

Top module: `ebus_seq`

## Requirements
- R1: The external-access mode output takes the value of `ea_pin_i` on the first clock after reset is released and keeps that value until the next reset, whatever `ea_pin_i` does in between.
- R2: With the latched mode high, `fetch_ext_o` is 0 for code addresses up to F7FFh and 1 for F800h and above. An internal fetch leaves `psen_n_o` high and the port in its plain-I/O state.
- R3: With the latched mode low, `fetch_ext_o` is 1 for every code address.
- R4: A slot is numbered in periods 0 to 5. In an external fetch slot, the port drives the low address byte with all enables set in periods 0 to 2. In periods 3 to 5, `psen_n_o` is low and all port enables are 0. The port input is captured at the end of period 5 and appears on `code_o`, with `code_vld_o` high for one cycle in the next period.
- R5: `ale_o` is high in periods 0 and 1 of idle, fetch and data-address slots, and low in the data-strobe slot. `psen_n_o`, `rd_n_o` and `wr_n_o` are high in every slot where they are not asserted, so at most one of the four strobes is active at any time.
- R6: While `ale_off_i` is 1, `ale_o` stays 0.
- R7: A data access is a data-address slot followed directly by a data-strobe slot. During the address slot the port drives address bits 7:0 with all enables set. During the access, `a_hi_o` shows bits 15:8 and `page_o` shows bits 23:16. During the strobe slot, `rd_n_o` (read) or `wr_n_o` (write) stays low for all six periods.
- R8: In a write strobe slot, the port drives the write data with all enables set. In a read strobe slot, all port enables are 0, the port input at the end of period 5 is placed on `rdata_o`, and `done_o` is high for one cycle after either kind of strobe slot.
- R9: In an idle slot, `p0_out_o` is 0 and `p0_oe_o` is the bitwise inverse of `p0_latch_i`, so a written 1 leaves that pin undriven.
- R10: `dl_mode_o` is 1 exactly when `psen_pin_i` was low on the first clock after reset is released, and it holds that value until the next reset.
- R11: A captured data request starts at the next slot boundary, ahead of a pending code fetch. A request that arrives while another is still waiting to start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_pin_i | input | 1 | External-access strap level |
| psen_pin_i | input | 1 | Level read back from the program-store pin |
| ale_off_i | input | 1 | Keeps the address latch strobe low |
| p0_latch_i | input | 8 | Plain-I/O latch value for the multiplexed port |
| p0_in_i | input | 8 | Levels read from the multiplexed port |
| fetch_req_i | input | 1 | Code fetch wanted (level) |
| fetch_addr_i | input | 16 | Code address |
| fetch_ext_o | output | 1 | Current code address is served externally |
| rd_req_i | input | 1 | Data read request pulse |
| wr_req_i | input | 1 | Data write request pulse |
| daddr_i | input | 24 | Data address, captured with the request |
| wdata_i | input | 8 | Write data, captured with the request |
| ale_o | output | 1 | Address latch strobe |
| psen_n_o | output | 1 | Program-store strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| p0_out_o | output | 8 | Multiplexed port output value |
| p0_oe_o | output | 8 | Multiplexed port per-bit drive enable |
| a_hi_o | output | 8 | High address byte |
| page_o | output | 8 | Page byte, data address bits 23:16 |
| code_o | output | 8 | Captured external code byte |
| code_vld_o | output | 1 | Code byte valid pulse |
| rdata_o | output | 8 | Captured read data byte |
| done_o | output | 1 | Data access finished pulse |
| ea_mode_o | output | 1 | Latched external-access mode |
| dl_mode_o | output | 1 | Serial-download flag |

## Verification
The assertions assume that data requests arrive as single-cycle pulses and that a new request is not raised while an earlier one is still waiting to start. Under those conditions the slot order and the strobe exclusivity hold. The stimulus raises each request for exactly one cycle and spaces successive requests more than a full access apart. It changes the strap pins only between resets, apart from one deliberate toggle that checks the straps are ignored after the first clock. The fetch address and the port input change only on falling edges, so each slot boundary samples a settled value.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
package ebus_pkg;
  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_FETCH = 2'd1,
    SL_DADDR = 2'd2,
    SL_DSTRB = 2'd3
  } slot_e;

  typedef enum logic [1:0] {
    DQ_NONE  = 2'd0,
    DQ_READ  = 2'd1,
    DQ_WRITE = 2'd2
  } dreq_e;
endpackage

// File: rtl/ebus_straps.sv
`timescale 1ns/1ps
module ebus_straps (
  input  logic clk,
  input  logic rst_n,
  input  logic ea_pin_i,
  input  logic psen_pin_i,
  output logic ea_mode_o,
  output logic dl_mode_o
);
  logic init_q, init_d;
  logic ea_q, ea_d;
  logic dl_q, dl_d;

  always_comb begin
    init_d = 1'b0;
    ea_d   = ea_q;
    dl_d   = dl_q;
    if (init_q) begin
      ea_d = ea_pin_i;
      dl_d = ~psen_pin_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      ea_q   <= 1'b0;
      dl_q   <= 1'b0;
    end else begin
      init_q <= init_d;
      ea_q   <= ea_d;
      dl_q   <= dl_d;
    end
  end

  assign ea_mode_o = ea_q;
  assign dl_mode_o = dl_q;

  AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |=> $stable(ea_mode_o)); // R1
  AST_DL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |=> $stable(dl_mode_o)); // R10
endmodule

// File: rtl/ebus_phase.sv
`timescale 1ns/1ps
module ebus_phase #(
  parameter int PHASES = 6,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    last_o = (ph_q == LAST);
    ph_d   = last_o ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign ph_o = ph_q;

  AST_PH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (ph_o == '0)); // R4
endmodule

// File: rtl/ebus_slot_ctrl.sv
`timescale 1ns/1ps
module ebus_slot_ctrl
  import ebus_pkg::*;
#(
  parameter int CADDR_W = 16,
  parameter int DADDR_W = 24,
  parameter int DATA_W  = 8,
  parameter logic [CADDR_W-1:0] INT_TOP = 16'hF7FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               last_i,
  input  logic               ea_mode_i,
  input  logic               fetch_req_i,
  input  logic [CADDR_W-1:0] fetch_addr_i,
  input  logic               rd_req_i,
  input  logic               wr_req_i,
  input  logic [DADDR_W-1:0] daddr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               fetch_ext_o,
  output slot_e              slot_o,
  output logic [CADDR_W-1:0] fa_o,
  output logic [DADDR_W-1:0] act_addr_o,
  output logic [DATA_W-1:0]  act_wdata_o,
  output logic               act_wr_o
);
  slot_e              slot_q, slot_d;
  dreq_e              pend_q, pend_d;
  logic [DADDR_W-1:0] paddr_q, paddr_d;
  logic [DATA_W-1:0]  pwd_q, pwd_d;
  logic [DADDR_W-1:0] aaddr_q, aaddr_d;
  logic [DATA_W-1:0]  awd_q, awd_d;
  logic               awr_q, awr_d;
  logic [CADDR_W-1:0] fa_q, fa_d;

  always_comb begin
    fetch_ext_o = ~ea_mode_i | (fetch_addr_i > INT_TOP);
    slot_d  = slot_q;
    pend_d  = pend_q;
    paddr_d = paddr_q;
    pwd_d   = pwd_q;
    aaddr_d = aaddr_q;
    awd_d   = awd_q;
    awr_d   = awr_q;
    fa_d    = fa_q;
    if (last_i) begin
      if (slot_q == SL_DADDR) begin
        slot_d = SL_DSTRB;
      end else if (pend_q != DQ_NONE) begin
        slot_d  = SL_DADDR;
        aaddr_d = paddr_q;
        awd_d   = pwd_q;
        awr_d   = (pend_q == DQ_WRITE);
        pend_d  = DQ_NONE;
      end else if (fetch_req_i && fetch_ext_o) begin
        slot_d = SL_FETCH;
        fa_d   = fetch_addr_i;
      end else begin
        slot_d = SL_IDLE;
      end
    end
    if ((pend_q == DQ_NONE) && (rd_req_i || wr_req_i)) begin
      pend_d  = wr_req_i ? DQ_WRITE : DQ_READ;
      paddr_d = daddr_i;
      pwd_d   = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= SL_IDLE;
      pend_q  <= DQ_NONE;
      paddr_q <= '0;
      pwd_q   <= '0;
      aaddr_q <= '0;
      awd_q   <= '0;
      awr_q   <= 1'b0;
      fa_q    <= '0;
    end else begin
      slot_q  <= slot_d;
      pend_q  <= pend_d;
      paddr_q <= paddr_d;
      pwd_q   <= pwd_d;
      aaddr_q <= aaddr_d;
      awd_q   <= awd_d;
      awr_q   <= awr_d;
      fa_q    <= fa_d;
    end
  end

  assign slot_o      = slot_q;
  assign fa_o        = fa_q;
  assign act_addr_o  = aaddr_q;
  assign act_wdata_o = awd_q;
  assign act_wr_o    = awr_q;

  AST_ADDR_THEN_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SL_DADDR && last_i) |=> (slot_q == SL_DSTRB)); // R7
  AST_STRB_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SL_DSTRB && $past(slot_q) != SL_DSTRB) |-> ($past(slot_q) == SL_DADDR)); // R7
  AST_PEND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_i && slot_q != SL_DADDR && pend_q != DQ_NONE) |=> (slot_q == SL_DADDR)); // R11
endmodule

// File: rtl/ebus_pins.sv
`timescale 1ns/1ps
module ebus_pins
  import ebus_pkg::*;
#(
  parameter int PHASES  = 6,
  parameter int ALE_W   = 2,
  parameter int CADDR_W = 16,
  parameter int DADDR_W = 24,
  parameter int DATA_W  = 8,
  localparam int PH_W   = $clog2(PHASES),
  localparam int HI_W   = CADDR_W - DATA_W,
  localparam int PG_W   = DADDR_W - CADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PH_W-1:0]    ph_i,
  input  logic               last_i,
  input  slot_e              slot_i,
  input  logic [CADDR_W-1:0] fa_i,
  input  logic [DADDR_W-1:0] act_addr_i,
  input  logic [DATA_W-1:0]  act_wdata_i,
  input  logic               act_wr_i,
  input  logic               ale_off_i,
  input  logic [DATA_W-1:0]  p0_latch_i,
  input  logic [DATA_W-1:0]  p0_in_i,
  output logic               ale_o,
  output logic               psen_n_o,
  output logic               rd_n_o,
  output logic               wr_n_o,
  output logic [DATA_W-1:0]  p0_out_o,
  output logic [DATA_W-1:0]  p0_oe_o,
  output logic [HI_W-1:0]    a_hi_o,
  output logic [PG_W-1:0]    page_o,
  output logic [DATA_W-1:0]  code_o,
  output logic               code_vld_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               done_o
);
  localparam logic [PH_W-1:0] ALE_END  = PH_W'(ALE_W);
  localparam logic [PH_W-1:0] STRB_BEG = PH_W'(PHASES / 2);

  logic              strb_half;
  logic [DATA_W-1:0] code_q, code_d;
  logic              cvld_q, cvld_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              done_q, done_d;

  always_comb begin
    strb_half = (ph_i >= STRB_BEG);
    ale_o     = ~ale_off_i && (slot_i != SL_DSTRB) && (ph_i < ALE_END);
    psen_n_o  = ~((slot_i == SL_FETCH) && strb_half);
    rd_n_o    = ~((slot_i == SL_DSTRB) && ~act_wr_i);
    wr_n_o    = ~((slot_i == SL_DSTRB) && act_wr_i);
    a_hi_o    = (slot_i == SL_FETCH) ? fa_i[CADDR_W-1:DATA_W]
                                     : act_addr_i[CADDR_W-1:DATA_W];
    page_o    = act_addr_i[DADDR_W-1:CADDR_W];
    unique case (slot_i)
      SL_FETCH: begin
        p0_out_o = strb_half ? '0 : fa_i[DATA_W-1:0];
        p0_oe_o  = strb_half ? '0 : '1;
      end
      SL_DADDR: begin
        p0_out_o = act_addr_i[DATA_W-1:0];
        p0_oe_o  = '1;
      end
      SL_DSTRB: begin
        p0_out_o = act_wr_i ? act_wdata_i : '0;
        p0_oe_o  = act_wr_i ? '1 : '0;
      end
      default: begin
        p0_out_o = '0;
        p0_oe_o  = ~p0_latch_i;
      end
    endcase
  end

  always_comb begin
    code_d = code_q;
    rdat_d = rdat_q;
    cvld_d = last_i && (slot_i == SL_FETCH);
    done_d = last_i && (slot_i == SL_DSTRB);
    if (cvld_d) code_d = p0_in_i;
    if (done_d && ~act_wr_i) rdat_d = p0_in_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cvld_q <= 1'b0;
      rdat_q <= '0;
      done_q <= 1'b0;
    end else begin
      code_q <= code_d;
      cvld_q <= cvld_d;
      rdat_q <= rdat_d;
      done_q <= done_d;
    end
  end

  assign code_o     = code_q;
  assign code_vld_o = cvld_q;
  assign rdata_o    = rdat_q;
  assign done_o     = done_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ale_o, ~psen_n_o, ~rd_n_o, ~wr_n_o})); // R5
  AST_STRB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((~rd_n_o || ~wr_n_o) && !last_i) |=> (~rd_n_o || ~wr_n_o)); // R7
  AST_PORT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ~psen_n_o |-> (p0_oe_o == '0)); // R4
  AST_DONE_AFTER_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(~rd_n_o || ~wr_n_o)); // R8
endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int CADDR_W = 16,
  parameter int DADDR_W = 24,
  parameter int DATA_W  = 8,
  parameter int PHASES  = 6,
  parameter int ALE_W   = 2,
  parameter logic [CADDR_W-1:0] INT_TOP = 16'hF7FF,
  localparam int PH_W   = $clog2(PHASES),
  localparam int HI_W   = CADDR_W - DATA_W,
  localparam int PG_W   = DADDR_W - CADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ea_pin_i,
  input  logic               psen_pin_i,
  input  logic               ale_off_i,
  input  logic [DATA_W-1:0]  p0_latch_i,
  input  logic [DATA_W-1:0]  p0_in_i,
  input  logic               fetch_req_i,
  input  logic [CADDR_W-1:0] fetch_addr_i,
  output logic               fetch_ext_o,
  input  logic               rd_req_i,
  input  logic               wr_req_i,
  input  logic [DADDR_W-1:0] daddr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               ale_o,
  output logic               psen_n_o,
  output logic               rd_n_o,
  output logic               wr_n_o,
  output logic [DATA_W-1:0]  p0_out_o,
  output logic [DATA_W-1:0]  p0_oe_o,
  output logic [HI_W-1:0]    a_hi_o,
  output logic [PG_W-1:0]    page_o,
  output logic [DATA_W-1:0]  code_o,
  output logic               code_vld_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               done_o,
  output logic               ea_mode_o,
  output logic               dl_mode_o
);
  logic [PH_W-1:0]    ph;
  logic               last;
  slot_e              slot;
  logic [CADDR_W-1:0] fa;
  logic [DADDR_W-1:0] act_addr;
  logic [DATA_W-1:0]  act_wdata;
  logic               act_wr;

  ebus_straps u_straps (
    .clk        (clk),
    .rst_n      (rst_n),
    .ea_pin_i   (ea_pin_i),
    .psen_pin_i (psen_pin_i),
    .ea_mode_o  (ea_mode_o),
    .dl_mode_o  (dl_mode_o)
  );

  ebus_phase #(.PHASES(PHASES)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph_o   (ph),
    .last_o (last)
  );

  ebus_slot_ctrl #(
    .CADDR_W(CADDR_W), .DADDR_W(DADDR_W), .DATA_W(DATA_W), .INT_TOP(INT_TOP)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .last_i       (last),
    .ea_mode_i    (ea_mode_o),
    .fetch_req_i  (fetch_req_i),
    .fetch_addr_i (fetch_addr_i),
    .rd_req_i     (rd_req_i),
    .wr_req_i     (wr_req_i),
    .daddr_i      (daddr_i),
    .wdata_i      (wdata_i),
    .fetch_ext_o  (fetch_ext_o),
    .slot_o       (slot),
    .fa_o         (fa),
    .act_addr_o   (act_addr),
    .act_wdata_o  (act_wdata),
    .act_wr_o     (act_wr)
  );

  ebus_pins #(
    .PHASES(PHASES), .ALE_W(ALE_W), .CADDR_W(CADDR_W),
    .DADDR_W(DADDR_W), .DATA_W(DATA_W)
  ) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .ph_i        (ph),
    .last_i      (last),
    .slot_i      (slot),
    .fa_i        (fa),
    .act_addr_i  (act_addr),
    .act_wdata_i (act_wdata),
    .act_wr_i    (act_wr),
    .ale_off_i   (ale_off_i),
    .p0_latch_i  (p0_latch_i),
    .p0_in_i     (p0_in_i),
    .ale_o       (ale_o),
    .psen_n_o    (psen_n_o),
    .rd_n_o      (rd_n_o),
    .wr_n_o      (wr_n_o),
    .p0_out_o    (p0_out_o),
    .p0_oe_o     (p0_oe_o),
    .a_hi_o      (a_hi_o),
    .page_o      (page_o),
    .code_o      (code_o),
    .code_vld_o  (code_vld_o),
    .rdata_o     (rdata_o),
    .done_o      (done_o)
  );

  AST_INT_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_mode_o && slot == SL_FETCH) |-> (fa > INT_TOP)); // R2
  AST_ALE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_off_i && slot == SL_DADDR) |-> !ale_o); // R6
endmodule

// File: tb/tb_ebus_seq.sv
`timescale 1ns/1ps
module tb_ebus_seq;
  localparam time T = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ea_pin = 1'b1, psen_pin = 1'b1, ale_off = 1'b0;
  logic [7:0]  p0_latch = 8'hA5, p0_in = 8'h00;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = 16'h0000;
  logic        rd_req = 1'b0, wr_req = 1'b0;
  logic [23:0] daddr = '0;
  logic [7:0]  wdata = '0;
  logic        fetch_ext, ale, psen_n, rd_n, wr_n, code_vld, done, ea_mode, dl_mode;
  logic [7:0]  p0_out, p0_oe, a_hi, page, code, rdata;

  ebus_seq dut (
    .clk(clk), .rst_n(rst_n), .ea_pin_i(ea_pin), .psen_pin_i(psen_pin),
    .ale_off_i(ale_off), .p0_latch_i(p0_latch), .p0_in_i(p0_in),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr), .fetch_ext_o(fetch_ext),
    .rd_req_i(rd_req), .wr_req_i(wr_req), .daddr_i(daddr), .wdata_i(wdata),
    .ale_o(ale), .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .p0_out_o(p0_out), .p0_oe_o(p0_oe), .a_hi_o(a_hi), .page_o(page),
    .code_o(code), .code_vld_o(code_vld), .rdata_o(rdata), .done_o(done),
    .ea_mode_o(ea_mode), .dl_mode_o(dl_mode)
  );

  always #(T/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  // behavioural reference model: slot 0 idle, 1 fetch, 2 data address, 3 data strobe
  int m_ph, m_slot, m_first, m_ea, m_dl, m_pend, m_paddr, m_pwd;
  int m_awr, m_aaddr, m_awd, m_fa, m_code, m_cvld, m_rdata, m_done;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ph = 0; m_slot = 0; m_first = 1; m_ea = 0; m_dl = 0; m_pend = 0;
      m_paddr = 0; m_pwd = 0; m_awr = 0; m_aaddr = 0; m_awd = 0; m_fa = 0;
      m_code = 0; m_cvld = 0; m_rdata = 0; m_done = 0;
    end else begin
      int oldpend;
      if (m_first) begin m_ea = ea_pin; m_dl = !psen_pin; m_first = 0; end
      m_cvld = (m_slot == 1 && m_ph == 5);
      if (m_cvld) m_code = p0_in;
      m_done = (m_slot == 3 && m_ph == 5);
      if (m_done && !m_awr) m_rdata = p0_in;
      oldpend = m_pend;
      if (m_ph == 5) begin
        if (m_slot == 2) m_slot = 3;
        else if (m_pend != 0) begin
          m_slot = 2; m_awr = (m_pend == 2); m_aaddr = m_paddr; m_awd = m_pwd; m_pend = 0;
        end else if (fetch_req && (!m_ea || fetch_addr > 16'hF7FF)) begin
          m_slot = 1; m_fa = fetch_addr;
        end else m_slot = 0;
      end
      if (oldpend == 0 && (rd_req || wr_req)) begin
        m_pend = wr_req ? 2 : 1; m_paddr = daddr; m_pwd = wdata;
      end
      m_ph = (m_ph == 5) ? 0 : m_ph + 1;
    end
  end

  task automatic chk(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, nm, act, exp, cycles);
    end
  endtask

  // compare every cycle, midway between falling and rising edges
  always @(negedge clk) begin
    #(T/4);
    if (rst_n && !finished) begin
      int e_oe, e_out;
      chk(ale_off ? "R6" : "R5", "ale", ale, !ale_off && m_slot != 3 && m_ph < 2);
      chk((m_slot >= 2) ? "R11" : "R4", "psen_n", psen_n, !(m_slot == 1 && m_ph >= 3));
      chk("R7", "rd_n", rd_n, !(m_slot == 3 && !m_awr));
      chk("R7", "wr_n", wr_n, !(m_slot == 3 && m_awr));
      case (m_slot)
        1: begin e_out = (m_ph < 3) ? (m_fa & 8'hFF) : 0; e_oe = (m_ph < 3) ? 8'hFF : 0; end
        2: begin e_out = m_aaddr & 8'hFF; e_oe = 8'hFF; end
        3: begin e_out = m_awr ? m_awd : 0; e_oe = m_awr ? 8'hFF : 0; end
        default: begin e_out = 0; e_oe = (~p0_latch) & 8'hFF; end
      endcase
      chk(m_slot == 0 ? "R9" : m_slot == 3 ? "R8" : m_slot == 1 ? "R4" : "R7", "p0_out", p0_out, e_out);
      chk(m_slot == 0 ? "R9" : m_slot == 3 ? "R8" : m_slot == 1 ? "R4" : "R7", "p0_oe", p0_oe, e_oe);
      chk("R7", "a_hi", a_hi, (m_slot == 1) ? ((m_fa >> 8) & 8'hFF) : ((m_aaddr >> 8) & 8'hFF));
      chk("R7", "page", page, (m_aaddr >> 16) & 8'hFF);
      chk("R4", "code_vld", code_vld, m_cvld);
      chk("R4", "code", code, m_code);
      chk("R8", "done", done, m_done);
      chk("R8", "rdata", rdata, m_rdata);
      chk("R1", "ea_mode", ea_mode, m_ea);
      chk("R10", "dl_mode", dl_mode, m_dl);
      chk(m_ea ? "R2" : "R3", "fetch_ext", fetch_ext, !m_ea || fetch_addr > 16'hF7FF);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd(logic [23:0] a);
    @(negedge clk); daddr = a; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic pulse_wr(logic [23:0] a, logic [7:0] d);
    @(negedge clk); daddr = a; wdata = d; wr_req = 1'b1;
    @(negedge clk); wr_req = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(T * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // first reset: external-access strap high, download pin high
    run(3);
    @(negedge clk); rst_n = 1'b1;
    #(T/2);
    chk("R5", "reset ale", ale, 1'b1);
    chk("R9", "reset p0_oe", p0_oe, 8'h5A);
    run(14);
    chk("R1", "ea latched high", ea_mode, 1'b1);
    chk("R10", "download flag clear", dl_mode, 1'b0);
    // R2: internal window stays quiet
    fetch_req = 1'b1; fetch_addr = 16'h1234;
    run(12);
    fetch_addr = 16'hF7FF;
    run(12);
    // R2/R4: just above the window goes out
    fetch_addr = 16'hF800; p0_in = 8'h3C;
    run(18);
    p0_in = 8'hC3;
    run(6);
    // R1: late strap change has no effect
    ea_pin = 1'b0; psen_pin = 1'b0;
    run(7);
    chk("R1", "ea unchanged", ea_mode, 1'b1);
    chk("R10", "download unchanged", dl_mode, 1'b0);
    // R11: data read while fetch is held; R7/R8
    p0_in = 8'h5A;
    pulse_rd(24'hABCDEF);
    run(20);
    pulse_wr(24'h010203, 8'h99);
    run(20);
    // R6: strobe switched off
    ale_off = 1'b1;
    pulse_rd(24'h7E55AA);
    run(24);
    ale_off = 1'b0;
    fetch_req = 1'b0; p0_latch = 8'h0F;
    run(12);
    // second reset: strap low, download pin low
    @(negedge clk); rst_n = 1'b0;
    run(3);
    @(negedge clk); rst_n = 1'b1;
    run(4);
    chk("R3", "ea latched low", ea_mode, 1'b0);
    chk("R10", "download flag set", dl_mode, 1'b1);
    ea_pin = 1'b1; psen_pin = 1'b1;
    // R3: low addresses go external
    fetch_req = 1'b1; fetch_addr = 16'h0010; p0_in = 8'h81;
    run(18);
    pulse_wr(24'hFF8001, 8'h00);
    run(20);
    p0_in = 8'hE7;
    pulse_rd(24'h00FFFF);
    run(24);
    fetch_req = 1'b0;
    run(12);
    summary();
  end
endmodule